// File: doc/BRIEF.md
# Resynchronizing Square-Wave Generator

This block drives a continuous square wave with equal high and low times. Both times are counted in whole cycles of the block clock, which serves as the timebase. The length of one half of the wave is a loadable input. The wave runs freely at that rate. An external reference pulse, asynchronous to the clock, pulls the wave back into phase. Each time the reference rises, the wave begins a fresh high phase, whatever it was doing before.

A typical use is a fast timing train, for example 80 Hz, locked to a slow reference near 1 Hz. Software, or a neighbouring block, measures the reference and keeps rewriting the half-period input. If reference pulses go missing, the wave carries on at its current rate without a gap. The half-period input may be changed while the wave runs. A new value takes effect only at a phase boundary.

Top module: `sqw_resync_gen`

## Requirements
- R1: While enabled and undisturbed, each high phase and each low phase of `wave_o` lasts exactly H clock cycles, where H is the half-period in use for that phase.
- R2: A rising reference edge forces `wave_o` high and restarts the high-phase count, even when `wave_o` is already high. The edge never simply inverts the output.
- R3: With no reference edges, `wave_o` keeps alternating with no gap and no stall.
- R4: After `ref_i` rises, `wave_o` is high from the third rising clock edge onward, whatever phase the output was in. That phase then lasts H cycles.
- R5: A change of `half_period_i` during a phase does not alter that phase. The new value is captured at the next phase boundary, or at a reference realignment.
- R6: After reset, `wave_o` is 0 and stays 0 while `half_period_i` is 0. The first clock edge that sees a nonzero value starts a high phase.
- R7: A half-period of 0, captured at a boundary, stops the wave low. Reference edges are then ignored until a nonzero value is applied.
- R8: `ref_i` passes through a synchronizer and a rising-edge detector. A reference held high for many cycles causes exactly one realignment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period_i | input | HP_W | Half-period in clock cycles; 0 disables |
| ref_i | input | 1 | Asynchronous reference pulse |
| wave_o | output | 1 | Registered square-wave output |

## Verification
A corrupted tick counter or captured half-period shows up at once as a high or low phase of the wrong length. It is visible within one half-period of the fault. A fault in the edge path appears three clock edges after a reference rise. It shows as a missing forced-high phase, an inverted phase, or a second realignment while the reference is held high. A bad idle state shows as activity on `wave_o` while the half-period is zero.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;
endpackage

// File: rtl/sqw_ref_edge.sv
module sqw_ref_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_async,
  output logic rise
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= ref_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[LAST];
  end

  assign rise = chain[LAST] & ~prev_q;

  // R8: an edge pulse is exactly one cycle wide
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/sqw_phase_engine.sv
module sqw_phase_engine
  import sqw_pkg::*;
#(
  parameter int HP_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HP_W-1:0] half_period_i,
  input  logic            realign,
  output logic            wave_o
);
  localparam logic [HP_W-1:0] ONE = HP_W'(1);

  phase_e          state_q, state_d;
  logic [HP_W-1:0] cnt_q, cnt_d;
  logic [HP_W-1:0] hp_q, hp_d;
  logic            wave_d;
  logic            load_ok;
  logic            at_end;

  assign load_ok = (half_period_i != '0);
  assign at_end  = (cnt_q == hp_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    hp_d    = hp_q;
    if (state_q == PH_IDLE) begin
      if (load_ok) begin
        state_d = PH_HIGH;
        cnt_d   = ONE;
        hp_d    = half_period_i;
      end
    end else if (realign || at_end) begin
      if (!load_ok) begin
        state_d = PH_IDLE;
        cnt_d   = '0;
        hp_d    = '0;
      end else begin
        state_d = (realign || state_q == PH_LOW) ? PH_HIGH : PH_LOW;
        cnt_d   = ONE;
        hp_d    = half_period_i;
      end
    end else begin
      cnt_d = cnt_q + ONE;
    end
    wave_d = (state_d == PH_HIGH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      hp_q    <= '0;
      wave_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hp_q    <= hp_d;
      wave_o  <= wave_d;
    end
  end

  // R2: a realignment while running with a valid value forces high
  p_force_high_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q != PH_IDLE && realign && load_ok) |=> wave_o);

  // R3: at a phase end without realignment, the output flips
  p_free_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q != PH_IDLE && !realign && at_end && load_ok) |=> (wave_o != $past(wave_o)));

  // R1: the tick count stays inside the active half-period
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q != PH_IDLE) |-> (cnt_q != '0 && cnt_q <= hp_q));

  // R5: the captured half-period holds inside a phase
  p_hp_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q != PH_IDLE && !realign && !at_end) |=> $stable(hp_q));

  // R6 / R7: idle means low
  p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_IDLE) |-> !wave_o);
endmodule

// File: rtl/sqw_resync_gen.sv
module sqw_resync_gen #(
  parameter int HP_W        = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HP_W-1:0] half_period_i,
  input  logic            ref_i,
  output logic            wave_o
);
  logic ref_rise;

  sqw_ref_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .ref_async (ref_i),
    .rise      (ref_rise)
  );

  sqw_phase_engine #(.HP_W(HP_W)) u_engine (
    .clk           (clk),
    .rst           (rst),
    .half_period_i (half_period_i),
    .realign       (ref_rise),
    .wave_o        (wave_o)
  );
endmodule

// File: tb/sqw_resync_gen_tb.sv
module sqw_resync_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HP_W = 24;
  localparam int NVEC = 7;
  // columns: half-period, idle cycles before the reference, reference width, cycles checked
  localparam int VEC [NVEC][4] = '{
    '{5, 0, 2, 40}, '{5, 7, 1, 40}, '{5, 13, 6, 30}, '{8, 3, 20, 50},
    '{3, 2, 4, 30}, '{1, 5, 3, 12}, '{12, 17, 2, 60}};

  logic clk = 1'b0;
  logic rst;
  logic [HP_W-1:0] half_period_i;
  logic ref_i;
  logic wave_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  sqw_resync_gen #(.HP_W(HP_W)) u_dut (
    .clk(clk), .rst(rst), .half_period_i(half_period_i), .ref_i(ref_i), .wave_o(wave_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: wave_o=%b expected %b", req, $time, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; half_period_i = '0; ref_i = 1'b0;
    idle(4);
    check(wave_o, 1'b0, "R6 reset");
    rst = 1'b0;
    // R6 / R7: zero half-period, a reference pulse must not wake the output
    for (int i = 0; i < 12; i++) begin
      ref_i = (i >= 2 && i < 5);
      @(negedge clk);
      check(wave_o, 1'b0, "R6 idle while zero");
    end
    ref_i = 1'b0;
    // R6: the first nonzero value starts a high phase on the next edge
    half_period_i = 24'd4;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check(wave_o, ((k / 4) % 2) == 0, "R6 start / R1 duty");
    end
    // Table walk: R2, R4 realignment from varied phases; R1 duty; R3 free run; R8 held reference
    for (int v = 0; v < NVEC; v++) begin
      idle(VEC[v][1]);
      half_period_i = HP_W'(VEC[v][0]);
      ref_i = 1'b1;
      for (int j = 1; j < 3 + VEC[v][3]; j++) begin
        @(negedge clk);
        if (j == VEC[v][2]) ref_i = 1'b0;
        if (j >= 3)
          check(wave_o, (((j - 3) / VEC[v][0]) % 2) == 0, "R2 R4 realign, R1 R3 R8 pattern");
      end
      ref_i = 1'b0;
    end
    // R5: change the half-period in mid-phase; the current phase keeps its length
    idle(3);
    half_period_i = 24'd6;
    ref_i = 1'b1;
    for (int j = 1; j < 3 + 36; j++) begin
      @(negedge clk);
      if (j == 2) ref_i = 1'b0;
      if (j >= 3) begin
        automatic int k = j - 3;
        automatic logic e = (k < 6) || (k >= 16 && k < 26);
        check(wave_o, e, "R5 boundary capture");
        if (k == 2) half_period_i = 24'd10;
      end
    end
    // R7: zero captured at a boundary stops the wave; references are ignored
    half_period_i = '0;
    idle(12);
    for (int i = 0; i < 30; i++) begin
      ref_i = (i >= 3 && i < 8);
      @(negedge clk);
      check(wave_o, 1'b0, "R7 disabled");
    end
    ref_i = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule